// File: doc/BRIEF.md
# Chip-Select Bus Write Sequencer

This block runs one single-beat write on an external, acknowledge-paced bus. An internal requester presents an address, write data, a size code, a transfer type and a user/supervisor flag. The block accepts the request when it is idle and then steps through the bus cycle one clock at a time. It drives a one-clock transfer-start strobe, an active-low chip select, active-low byte-lane write enables and the write data. It also watches an active-low acknowledge input, so that a slow device can stretch the cycle with wait states.

Two configuration inputs change the cycle. With address setup enabled, chip select is held back by one clock so that the address settles before the device is selected. With the bus monitor enabled, a cycle that gets no acknowledge within a programmed number of clocks is aborted, and the requester gets an error pulse in place of the completion pulse. All bus-side outputs come straight from flops.

Top module: `csel_wr_seq`

## Requirements
- R1: Out of reset and while idle: `ts_n`, `cs_n` and every `we_n` bit are high, `bus_rw` is high, and `busy`, `done`, `berr` and `data_oe` are low.
- R2: When `req_valid` is high at a clock edge while `busy` is low, the cycle starts. In the clock that follows (clock 1), `ts_n` is low for that clock only, `bus_rw` is low, `bus_atm` is low, `busy` is high, and `bus_addr`, `bus_tt` and `bus_size` carry the request. The address stays constant until the cycle ends.
- R3: With `setup_en` high, `cs_n` stays high in clock 1 and goes low from clock 2. With `setup_en` low, `cs_n` goes low in clock 1. In both cases it stays low until the cycle ends.
- R4: From clock 2 on, `ts_n` is high, `data_oe` is high, and `bus_atm` is 0 for a user request and 1 for a supervisor request. Data is left-justified on `bus_data`. Size 1 (byte) puts data bits 7:0 on the top byte lane. Size 2 (word) puts data bits 15:0 on the upper half. Size 0 (long) puts the whole word on the bus, and size 3 is handled as long.
- R5: `ta_n` is sampled on the rising edge at the end of each clock from clock 2 on. If it is high, one more clock is added and the bus outputs hold their values.
- R6: The write enables go low only from clock 3 on. Bit i of `we_n` is byte lane i (bits 8i+7:8i). Byte writes enable the top lane, word writes enable the top two lanes, and long writes enable all lanes. A cycle acknowledged at the end of clock 2 never asserts a write enable.
- R7: At the edge where `ta_n` is sampled low, `cs_n` and `we_n` return high, `busy` drops, and `done` is high for exactly one clock.
- R8: With `mon_en` high, a cycle that has not been acknowledged when its length reaches max(`mon_limit`, 2) clocks ends at the close of that clock. `berr` is then high for one clock and `done` stays low. If acknowledge is sampled at that same edge, the acknowledge wins.
- R9: With `mon_en` low, a cycle waits for acknowledge for any number of clocks.
- R10: A `req_valid` seen while `busy` is high is ignored. It does not change the bus outputs, and no second cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request |
| req_addr | input | AW | Request address |
| req_data | input | 8*NB | Write data, right-justified |
| req_size | input | 2 | 0 long, 1 byte, 2 word, 3 long |
| req_tt | input | 2 | Transfer type, passed to the bus |
| req_user | input | 1 | 1 user mode, 0 supervisor |
| setup_en | input | 1 | Delay chip select by one clock |
| mon_en | input | 1 | Enable bus monitor timeout |
| mon_limit | input | CW | Timeout length in clocks |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock pulse, acknowledged finish |
| berr | output | 1 | One-clock pulse, timeout finish |
| bus_addr | output | AW | Address bus |
| bus_tt | output | 2 | Transfer type |
| bus_size | output | 2 | Size code |
| bus_atm | output | 1 | Access mode: 0 in clock 1, then user 0 / supervisor 1 |
| bus_rw | output | 1 | 1 read/idle, 0 write |
| ts_n | output | 1 | Transfer start, active low |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | NB | Byte-lane write enables, active low |
| bus_data | output | 8*NB | Write data bus |
| data_oe | output | 1 | Data bus driven |
| ta_n | input | 1 | Transfer acknowledge, active low |

## Verification
The hardest situation to reach is the tie between the bus monitor expiring and the acknowledge arriving in the same clock, because the outcome depends on both the programmed limit and the device latency. The bench draws both numbers per cycle from a seeded generator and, separately, runs cycles with the latency set exactly at the limit, one below it and one above it, including limits of 0 and 1 that clamp to 2. Zero-wait cycles with setup on and off, and requests raised in the middle of a cycle, are driven as directed cases.

// File: rtl/csw_pkg.sv
package csw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_C1   = 2'd1,
    ST_C2   = 2'd2,
    ST_WAIT = 2'd3
  } csw_state_e;

  localparam logic [1:0] SZ_LONG = 2'd0;
  localparam logic [1:0] SZ_BYTE = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Number of byte lanes a size code covers, clamped to the bus width.
  function automatic int unsigned size_lanes(input logic [1:0] sz, input int unsigned nb);
    int unsigned n;
    case (sz)
      SZ_BYTE: n = 1;
      SZ_WORD: n = 2;
      default: n = 4;
    endcase
    if (n > nb) n = nb;
    return n;
  endfunction
endpackage

// File: rtl/csw_ctrl.sv
module csw_ctrl
  import csw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       ta_n,
  input  logic       timeout,
  output csw_state_e state_q,
  output csw_state_e state_d,
  output logic       accept,
  output logic       fin_ok,
  output logic       fin_err
);
  logic in_data;

  always_comb begin
    in_data = (state_q == ST_C2) || (state_q == ST_WAIT);
    accept  = (state_q == ST_IDLE) && req_valid;
    fin_ok  = in_data && !ta_n;
    fin_err = in_data && ta_n && timeout;
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_C1;
      ST_C1:   state_d = ST_C2;
      default: begin
        if (!ta_n)        state_d = ST_IDLE;
        else if (timeout) state_d = ST_IDLE;
        else              state_d = ST_WAIT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/csw_busmon.sv
module csw_busmon #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          active,
  input  logic          mon_en,
  input  logic [CW-1:0] mon_limit,
  output logic          timeout
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [CW:0]   MIN_LEN = (CW+1)'(2);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   elapsed;
  logic [CW:0]   eff_limit;

  // cnt_q holds the number of clocks already completed in this cycle.
  always_ff @(posedge clk) begin
    if (rst || accept)                cnt_q <= '0;
    else if (active && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    elapsed   = {1'b0, cnt_q} + 1'b1;
    eff_limit = ({1'b0, mon_limit} < MIN_LEN) ? MIN_LEN : {1'b0, mon_limit};
    timeout   = mon_en && (elapsed >= eff_limit);
  end
endmodule

// File: rtl/csw_outreg.sv
module csw_outreg
  import csw_pkg::*;
#(
  parameter int AW = 24,
  parameter int NB = 4,
  localparam int DW = 8 * NB
) (
  input  logic          clk,
  input  logic          rst,
  input  csw_state_e    state_d,
  input  logic          accept,
  input  logic          fin_ok,
  input  logic          fin_err,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [1:0]    req_size,
  input  logic [1:0]    req_tt,
  input  logic          req_user,
  input  logic          setup_en,
  output logic          busy,
  output logic          done,
  output logic          berr,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_tt,
  output logic [1:0]    bus_size,
  output logic          bus_atm,
  output logic          bus_rw,
  output logic          ts_n,
  output logic          cs_n,
  output logic [NB-1:0] we_n,
  output logic [DW-1:0] bus_data,
  output logic          data_oe
);
  int unsigned   lanes;
  logic [NB-1:0] lane_en;
  logic [DW-1:0] placed;
  logic [NB-1:0] mask_q;
  logic [DW-1:0] data_q;
  logic          user_q;
  logic          drive_data;

  always_comb begin
    lanes  = size_lanes(req_size, NB);
    placed = req_data << ((NB - lanes) * 8);
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign lane_en[i] = (i >= (NB - lanes));
  end

  assign drive_data = (state_d == ST_C2) || (state_d == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      data_q   <= '0;
      user_q   <= 1'b0;
      bus_addr <= '0;
      bus_tt   <= '0;
      bus_size <= '0;
    end else if (accept) begin
      mask_q   <= lane_en;
      data_q   <= placed;
      user_q   <= req_user;
      bus_addr <= req_addr;
      bus_tt   <= req_tt;
      bus_size <= req_size;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      berr     <= 1'b0;
      bus_atm  <= 1'b0;
      bus_rw   <= 1'b1;
      ts_n     <= 1'b1;
      cs_n     <= 1'b1;
      we_n     <= '1;
      bus_data <= '0;
      data_oe  <= 1'b0;
    end else begin
      busy    <= (state_d != ST_IDLE);
      done    <= fin_ok;
      berr    <= fin_err;
      bus_rw  <= (state_d == ST_IDLE);
      ts_n    <= (state_d != ST_C1);
      data_oe <= drive_data;
      case (state_d)
        ST_C1:   cs_n <= setup_en;
        ST_IDLE: cs_n <= 1'b1;
        default: cs_n <= 1'b0;
      endcase
      we_n     <= (state_d == ST_WAIT) ? ~mask_q : '1;
      bus_atm  <= drive_data ? ~user_q : 1'b0;
      bus_data <= drive_data ? data_q : '0;
    end
  end
endmodule

// File: rtl/csel_wr_seq.sv
module csel_wr_seq
  import csw_pkg::*;
#(
  parameter int AW = 24,
  parameter int NB = 4,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic [8*NB-1:0] req_data,
  input  logic [1:0]      req_size,
  input  logic [1:0]      req_tt,
  input  logic            req_user,
  input  logic            setup_en,
  input  logic            mon_en,
  input  logic [CW-1:0]   mon_limit,
  output logic            busy,
  output logic            done,
  output logic            berr,
  output logic [AW-1:0]   bus_addr,
  output logic [1:0]      bus_tt,
  output logic [1:0]      bus_size,
  output logic            bus_atm,
  output logic            bus_rw,
  output logic            ts_n,
  output logic            cs_n,
  output logic [NB-1:0]   we_n,
  output logic [8*NB-1:0] bus_data,
  output logic            data_oe,
  input  logic            ta_n
);
  csw_state_e state_q, state_d;
  logic accept, fin_ok, fin_err, timeout;

  csw_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .ta_n(ta_n), .timeout(timeout),
    .state_q(state_q), .state_d(state_d), .accept(accept),
    .fin_ok(fin_ok), .fin_err(fin_err)
  );

  csw_busmon #(.CW(CW)) u_mon (
    .clk(clk), .rst(rst), .accept(accept), .active(state_q != ST_IDLE),
    .mon_en(mon_en), .mon_limit(mon_limit), .timeout(timeout)
  );

  csw_outreg #(.AW(AW), .NB(NB)) u_out (
    .clk(clk), .rst(rst), .state_d(state_d), .accept(accept),
    .fin_ok(fin_ok), .fin_err(fin_err),
    .req_addr(req_addr), .req_data(req_data), .req_size(req_size),
    .req_tt(req_tt), .req_user(req_user), .setup_en(setup_en),
    .busy(busy), .done(done), .berr(berr), .bus_addr(bus_addr),
    .bus_tt(bus_tt), .bus_size(bus_size), .bus_atm(bus_atm), .bus_rw(bus_rw),
    .ts_n(ts_n), .cs_n(cs_n), .we_n(we_n), .bus_data(bus_data), .data_oe(data_oe)
  );
endmodule

// File: rtl/csw_chk.sv
module csw_chk #(
  parameter int AW = 24,
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          setup_en,
  input logic          ts_n,
  input logic          cs_n,
  input logic [NB-1:0] we_n,
  input logic          bus_rw,
  input logic          busy,
  input logic          done,
  input logic          berr,
  input logic [AW-1:0] bus_addr
);
  assert_ts_one_clock_R2: assert property (@(posedge clk) disable iff (rst)
    !ts_n |=> ts_n);

  assert_ts_write_R2: assert property (@(posedge clk) disable iff (rst)
    !ts_n |-> (!bus_rw && busy));

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(bus_addr));

  assert_setup_cs_R3: assert property (@(posedge clk) disable iff (rst)
    !ts_n |-> (cs_n == $past(setup_en)));

  assert_cs_clock2_R3: assert property (@(posedge clk) disable iff (rst)
    !ts_n |=> !cs_n);

  assert_no_we_early_R6: assert property (@(posedge clk) disable iff (rst)
    !ts_n |=> (&we_n));

  assert_we_needs_cs_R6: assert property (@(posedge clk) disable iff (rst)
    !(&we_n) |-> (!cs_n && busy));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && (&we_n) && !busy));

  assert_single_end_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, berr}));

  assert_berr_idle_R8: assert property (@(posedge clk) disable iff (rst)
    berr |-> (cs_n && !busy));
endmodule

bind csel_wr_seq csw_chk #(.AW(AW), .NB(NB)) u_chk (
  .clk(clk), .rst(rst), .setup_en(setup_en), .ts_n(ts_n), .cs_n(cs_n),
  .we_n(we_n), .bus_rw(bus_rw), .busy(busy), .done(done), .berr(berr),
  .bus_addr(bus_addr)
);

// File: tb/sim_csel_wr_seq.sv
module sim_csel_wr_seq;
  localparam int AW = 24;
  localparam int NB = 4;
  localparam int DW = 32;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [1:0] req_size = '0;
  logic [1:0] req_tt = '0;
  logic req_user = 1'b0;
  logic setup_en = 1'b0;
  logic mon_en = 1'b0;
  logic [CW-1:0] mon_limit = '0;
  logic ta_n = 1'b1;
  logic busy, done, berr, bus_atm, bus_rw, ts_n, cs_n, data_oe;
  logic [AW-1:0] bus_addr;
  logic [1:0] bus_tt, bus_size;
  logic [NB-1:0] we_n;
  logic [DW-1:0] bus_data;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  csel_wr_seq #(.AW(AW), .NB(NB), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_size(req_size), .req_tt(req_tt),
    .req_user(req_user), .setup_en(setup_en), .mon_en(mon_en),
    .mon_limit(mon_limit), .busy(busy), .done(done), .berr(berr),
    .bus_addr(bus_addr), .bus_tt(bus_tt), .bus_size(bus_size),
    .bus_atm(bus_atm), .bus_rw(bus_rw), .ts_n(ts_n), .cs_n(cs_n),
    .we_n(we_n), .bus_data(bus_data), .data_oe(data_oe), .ta_n(ta_n)
  );

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] exp_we(input logic [1:0] sz);
    case (sz)
      2'd1:    return 4'b0111;
      2'd2:    return 4'b0011;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_data(input logic [1:0] sz, input logic [DW-1:0] d);
    case (sz)
      2'd1:    return {d[7:0], 24'h0};
      2'd2:    return {d[15:0], 16'h0};
      default: return d;
    endcase
  endfunction

  // One full write cycle. w = wait states before acknowledge.
  task automatic run_cycle(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [1:0] sz, input logic [1:0] tt, input logic usr,
                           input logic su, input logic me, input int lim,
                           input int w, input logic inject);
    int ack_clk, eff, len;
    logic is_err;
    ack_clk = 2 + w;
    eff = (lim < 2) ? 2 : lim;
    is_err = me && (eff < ack_clk);
    len = is_err ? eff : ack_clk;
    @(negedge clk);
    req_addr = a; req_data = d; req_size = sz; req_tt = tt; req_user = usr;
    setup_en = su; mon_en = me; mon_limit = CW'(lim); ta_n = 1'b1; req_valid = 1'b1;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      if (k == 1) begin
        if (inject) begin
          req_addr = ~a;
          req_valid = 1'b1;
        end else req_valid = 1'b0;
        chk("R2", "ts_n clock1", ts_n, 0);
        chk("R2", "rw clock1", bus_rw, 0);
        chk("R2", "atm clock1", bus_atm, 0);
        chk("R2", "tt", bus_tt, tt);
        chk("R2", "size", bus_size, sz);
        chk("R3", "cs_n clock1", cs_n, su);
        chk("R6", "we_n clock1", we_n, 4'hF);
      end else begin
        if (k == 2) req_valid = 1'b0;
        chk("R4", "ts_n", ts_n, 1);
        chk("R3", "cs_n", cs_n, 0);
        chk("R4", "atm", bus_atm, !usr);
        chk("R4", "data_oe", data_oe, 1);
        chk("R4", "data", bus_data, exp_data(sz, d));
        chk("R6", "we_n", we_n, (k >= 3) ? exp_we(sz) : 4'hF);
        chk("R5", "rw held", bus_rw, 0);
      end
      chk(inject ? "R10" : "R2", "addr", bus_addr, a);
      chk("R5", "busy", busy, 1);
      chk("R9", "no early end", done | berr, 0);
      ta_n = (k == ack_clk) ? 1'b0 : 1'b1;
    end
    @(negedge clk);
    ta_n = 1'b1;
    chk("R7", "cs_n end", cs_n, 1);
    chk("R7", "we_n end", we_n, 4'hF);
    chk("R7", "busy end", busy, 0);
    chk(is_err ? "R8" : "R7", "done", done, !is_err);
    chk("R8", "berr", berr, is_err);
    @(negedge clk);
    chk("R7", "done pulse width", done, 0);
    chk("R8", "berr pulse width", berr, 0);
    chk("R10", "no second cycle", busy, 0);
    chk("R1", "idle ts_n", ts_n, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ts_n", ts_n, 1);
    chk("R1", "cs_n", cs_n, 1);
    chk("R1", "we_n", we_n, 4'hF);
    chk("R1", "rw", bus_rw, 1);
    chk("R1", "busy", busy, 0);
    chk("R1", "done/berr", done | berr, 0);
    chk("R1", "data_oe", data_oe, 0);

    // Directed corner cases
    run_cycle(24'h00A5A5, 32'h1234_5678, 2'd2, 2'd1, 1'b1, 1'b1, 1'b0, 0, 0, 1'b0); // R6 zero wait, setup
    run_cycle(24'h001234, 32'hDEAD_BEEF, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0); // R3 no setup
    run_cycle(24'h0F0F0F, 32'h0000_00C3, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 0, 3, 1'b1); // R10 inject
    run_cycle(24'h111111, 32'hCAFE_F00D, 2'd3, 2'd3, 1'b0, 1'b1, 1'b1, 0, 5, 1'b0); // R8 limit 0 clamps
    run_cycle(24'h222222, 32'h0BAD_CAFE, 2'd2, 2'd1, 1'b1, 1'b0, 1'b1, 1, 0, 1'b0); // R8 tie at clamp
    run_cycle(24'h333333, 32'h5555_AAAA, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 6, 4, 1'b0); // R8 ack wins tie
    run_cycle(24'h444444, 32'hA5A5_5A5A, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 6, 5, 1'b0); // R8 one late
    run_cycle(24'h555555, 32'h0102_0304, 2'd2, 2'd2, 1'b0, 1'b1, 1'b1, 6, 3, 1'b0); // R8 one early
    run_cycle(24'h666666, 32'h7777_8888, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 3, 40, 1'b0); // R9 long wait

    // Seeded random cycles
    void'($urandom(32'd5207));
    for (int n = 0; n < 60; n++) begin
      run_cycle(AW'($urandom), $urandom, 2'($urandom), 2'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), int'($urandom % 16), int'($urandom % 14),
                1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule